// File: doc/BRIEF.md
# Strap-Selected Host Interface Mode

This block picks one of three host-interface personalities for a disk controller front end: an AT-compatible mode, a PS/2 mode and a Model 30 mode. It reads two configuration straps, a select strap and an auxiliary strap, on every clock edge while reset is held. The value seen on the last edge before reset is released stays latched until the next reset.

From the latched mode, the block turns the raw terminal-count input into an internal active-high signal. It also decides whether the host's DMA-enable bit controls the output enables of the interrupt and DMA-request pins. The density-select pin level follows the live select strap, not the latched mode. Board logic can therefore flip that polarity after reset without disturbing the host personality.

Top module: `hostmode_strap`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads the mode from the straps. The mode latched when reset is released is the one decoded on the last edge with `rst_n` low.
- R2: If `strap_sel` is 1 at capture, the mode is AT, coded `mode_code` = 0, whatever the value of `strap_aux`.
- R3: If `strap_sel` is 0 and `strap_aux` is 1 at capture, the mode is PS/2, coded `mode_code` = 1.
- R4: If both straps are 0 at capture, the mode is Model 30, coded `mode_code` = 2. Code 3 never appears.
- R5: While `rst_n` is high, changes on either strap leave `mode_code` unchanged.
- R6: `tc_norm` equals `tc_raw` in modes AT and Model 30, and equals the inverse of `tc_raw` in PS/2, so that `tc_norm` is always active high.
- R7: `densel_pin` equals `dens_int` while the live `strap_sel` is 1, and equals its inverse while `strap_sel` is 0. This holds in every mode and at any time after reset.
- R8: In modes AT and Model 30, `int_oe` and `drq_oe` both equal `dma_en`.
- R9: In PS/2 mode, `int_oe` and `drq_oe` are both 1 whatever the value of `dma_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; straps are captured while it is low |
| strap_sel | input | 1 | Select strap; captured for the mode and also used live for density polarity |
| strap_aux | input | 1 | Auxiliary strap; used only at capture when `strap_sel` is 0 |
| tc_raw | input | 1 | Terminal count as seen at the pin |
| dens_int | input | 1 | Internal density-select value (1 = high density) |
| dma_en | input | 1 | DMA-enable bit from the digital output register |
| mode_code | output | 2 | Latched mode: 0 AT, 1 PS/2, 2 Model 30 |
| tc_norm | output | 1 | Terminal count, active high |
| densel_pin | output | 1 | Density-select pin level |
| int_oe | output | 1 | Output enable of the interrupt pin (0 = high impedance) |
| drq_oe | output | 1 | Output enable of the DMA-request pin (0 = high impedance) |

## Verification
On every cycle outside reset, the assertions check the following. The mode holds steady, and code 3 never appears. The terminal-count inversion and the enable gating follow the latched mode. Any edge on the select strap, with the density value steady, flips the pin level. On the first cycle after release, they also check that the captured mode matches the straps of the last reset edge. Only the bench scenarios can show the following. The last-edge-wins rule applies when the straps change partway through a reset. Every combination of live inputs gives the right output levels for each of the three captured modes.

// File: rtl/strapmode_pkg.sv
package strapmode_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_AT  = 2'd0,
        MODE_PS2 = 2'd1,
        MODE_M30 = 2'd2
    } hostmode_e;

    typedef struct packed {
        hostmode_e mode;
    } latch_t;

    function automatic hostmode_e decode_straps(input logic sel, input logic aux);
        if (sel) begin
            return MODE_AT;
        end else if (aux) begin
            return MODE_PS2;
        end else begin
            return MODE_M30;
        end
    endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import strapmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap_sel,
    input  logic      strap_aux,
    output hostmode_e mode_o
);

    latch_t st_d;
    latch_t st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.mode = decode_straps(strap_sel, strap_aux);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o = st_q.mode;

    // R5: mode is frozen outside reset
    a_r5_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(st_q.mode));

    // R4: the unused code never appears
    a_r4_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode != hostmode_e'(2'd3));

    // R1: the first cycle after release shows the straps of the last reset edge
    a_r1_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> st_q.mode == decode_straps($past(strap_sel), $past(strap_aux)));

endmodule

// File: rtl/polarity_map.sv
module polarity_map
    import strapmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hostmode_e mode_i,
    input  logic      strap_sel,
    input  logic      tc_raw,
    input  logic      dens_int,
    output logic      tc_norm,
    output logic      densel_pin
);

    logic tc_low_active;

    always_comb begin
        tc_low_active = (mode_i == MODE_PS2);
        tc_norm       = tc_raw ^ tc_low_active;
        densel_pin    = strap_sel ? dens_int : ~dens_int;
    end

    // R6: PS/2 inverts terminal count, the other modes pass it through
    a_r6_tc_ps2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PS2) |-> (tc_norm != tc_raw));
    a_r6_tc_other: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_PS2) |-> (tc_norm == tc_raw));

    // R7: a live strap edge with steady density flips the pin level
    a_r7_densel_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && strap_sel != $past(strap_sel) && dens_int == $past(dens_int))
        |-> densel_pin != $past(densel_pin));

endmodule

// File: rtl/oe_gate.sv
module oe_gate
    import strapmode_pkg::*;
#(
    parameter int N_GATED = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  hostmode_e          mode_i,
    input  logic               dma_en,
    output logic [N_GATED-1:0] oe_o
);

    logic force_on;

    assign force_on = (mode_i == MODE_PS2);

    for (genvar g = 0; g < N_GATED; g++) begin : g_oe
        assign oe_o[g] = force_on | dma_en;

        // R9: PS/2 always drives
        a_r9_always_on: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == MODE_PS2) |-> oe_o[g]);
        // R8: other modes follow the enable bit
        a_r8_follow_en: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i != MODE_PS2) |-> (oe_o[g] == dma_en));
    end

endmodule

// File: rtl/hostmode_strap.sv
module hostmode_strap
    import strapmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_sel,
    input  logic              strap_aux,
    input  logic              tc_raw,
    input  logic              dens_int,
    input  logic              dma_en,
    output logic [MODE_W-1:0] mode_code,
    output logic              tc_norm,
    output logic              densel_pin,
    output logic              int_oe,
    output logic              drq_oe
);

    localparam int N_GATED = 2;

    hostmode_e          mode_q;
    logic [N_GATED-1:0] oe_vec;

    strap_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_sel (strap_sel),
        .strap_aux (strap_aux),
        .mode_o    (mode_q)
    );

    polarity_map u_pol (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_q),
        .strap_sel  (strap_sel),
        .tc_raw     (tc_raw),
        .dens_int   (dens_int),
        .tc_norm    (tc_norm),
        .densel_pin (densel_pin)
    );

    oe_gate #(.N_GATED(N_GATED)) u_oe (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_q),
        .dma_en (dma_en),
        .oe_o   (oe_vec)
    );

    assign mode_code = mode_q;
    assign int_oe    = oe_vec[0];
    assign drq_oe    = oe_vec[1];

endmodule

// File: tb/hostmode_strap_bench.sv
module hostmode_strap_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_sel = 1'b0;
    logic       strap_aux = 1'b0;
    logic       tc_raw = 1'b0;
    logic       dens_int = 1'b0;
    logic       dma_en = 1'b0;
    logic [1:0] mode_code;
    logic       tc_norm;
    logic       densel_pin;
    logic       int_oe;
    logic       drq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hostmode_strap u_hostmode_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_sel  (strap_sel),
        .strap_aux  (strap_aux),
        .tc_raw     (tc_raw),
        .dens_int   (dens_int),
        .dma_en     (dma_en),
        .mode_code  (mode_code),
        .tc_norm    (tc_norm),
        .densel_pin (densel_pin),
        .int_oe     (int_oe),
        .drq_oe     (drq_oe)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic int exp_mode(input logic sel, input logic aux);
        return sel ? 0 : (aux ? 1 : 2);
    endfunction

    task automatic do_reset(input logic sel, input logic aux);
        @(negedge clk);
        rst_n     = 1'b0;
        strap_sel = ~sel;
        strap_aux = ~aux;
        @(posedge clk);
        #2;
        // R1: mode follows straps during reset
        check("R1 in-reset capture", mode_code, exp_mode(~sel, ~aux));
        @(negedge clk);
        strap_sel = sel;
        strap_aux = aux;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int r = 0; r < 4; r++) begin
            logic rs;
            logic ra;
            int   m;
            rs = r[1];
            ra = r[0];
            m  = exp_mode(rs, ra);
            do_reset(rs, ra);
            @(posedge clk);
            #2;
            // R1/R2/R3/R4: last reset edge wins
            if (rs) check("R2 AT capture", mode_code, 0);
            else if (ra) check("R3 PS2 capture", mode_code, 1);
            else check("R4 M30 capture", mode_code, 2);
            check("R1 last edge", mode_code, m);
            for (int v = 0; v < 32; v++) begin
                @(negedge clk);
                strap_sel = v[4];
                strap_aux = v[3];
                tc_raw    = v[2];
                dens_int  = v[1];
                dma_en    = v[0];
                @(posedge clk);
                #2;
                check("R5 mode held", mode_code, m);
                check("R6 tc_norm", tc_norm, (m == 1) ? int'(!v[2]) : int'(v[2]));
                check("R7 densel", densel_pin, v[4] ? int'(v[1]) : int'(!v[1]));
                if (m == 1) begin
                    check("R9 int_oe", int_oe, 1);
                    check("R9 drq_oe", drq_oe, 1);
                end else begin
                    check("R8 int_oe", int_oe, int'(v[0]));
                    check("R8 drq_oe", drq_oe, int'(v[0]));
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule